// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank synchronous DRAM. It owns the command bus from reset until the memory is ready for use. While the clock-stable flag is low, it holds the chip deselected. Once the flag goes high, it drives NOPs for a power-up interval that is set in clock cycles from a clock-frequency parameter. After that it issues a fixed script: a precharge to every bank, two auto-refreshes, a load of the main mode register, and a load of the extended mode register. Each command is followed by its own cycle-counted NOP gap.

The main mode word is assembled from separate field inputs: burst length, burst type, CAS latency and write-burst mode. The operating-mode and reserved bits are forced to zero. The extended word is taken whole from an input. When the last gap ends, a done flag rises and stays high until reset. From then on the block drives NOP, so the normal-operation logic can take over the bus.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: During reset and in the first cycle after it, the outputs are COMMAND INHIBIT ({cs_n,ras_n,cas_n,we_n}=1111), addr=0, ba=0 and init_done=0.
- R2: While clk_stable has not been seen high, COMMAND INHIBIT is driven. The cycle after clk_stable is first sampled high starts a run of exactly WAIT_CYC = CLK_MHZ*WAIT_US NOP cycles ({cs_n,ras_n,cas_n,we_n}=0111, addr=0, ba=0).
- R3: If clk_stable is sampled low before the power-up wait completes, the block returns to COMMAND INHIBIT. When clk_stable is seen high again, a full WAIT_CYC NOP run restarts.
- R4: The cycle after the wait, one PRECHARGE ALL is driven (0010, addr=12'h400 so that only bit 10 is set, ba=0). It is followed by T_RP NOP cycles.
- R5: Exactly REF_COUNT (default 2) AUTO REFRESH commands (0001, addr=0, ba=0) follow. Each is followed by T_RFC NOP cycles.
- R6: A LOAD MODE REGISTER command (0000, ba=00) then carries addr[2:0]=burst length, addr[3]=burst type, addr[6:4]=CAS latency, addr[8:7]=0, addr[9]=write-burst mode and addr[11:10]=0.
- R7: After T_MRD NOP cycles, a second load command (0000) with ba=2'b10 carries the extended word unchanged. It is followed by T_MRD NOP cycles.
- R8: init_done rises in the cycle after the last of those NOPs and stays high until reset. While init_done is high, the command is NOP.
- R9: Changes on clk_stable after the power-up wait has completed do not alter the command script or init_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_stable | input | 1 | High once the memory clock is within its limits |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_burst_type | input | 1 | Burst type bit (sequential/interleaved) |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_write_burst | input | 1 | Write-burst mode bit |
| cfg_ext_word | input | ADDR_W | Word written to the extended mode register |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | High once initialization is complete |

## Verification
The bench compares every cycle of the script against an expected stream, so a gap that is one NOP long or short shows up as a misaligned command. It drops clk_stable partway through the power-up wait. A sequencer that kept counting instead of restarting would issue the precharge too early. It also drops clk_stable after the wait, where a design that still watched the flag would stall or restart. Two field sets with distinct bit patterns catch a mode word with a swapped or misplaced field, and comparing the bank bits catches an extended load sent to the main register.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOAD = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111,
    CMD_INH  = 4'b1111
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_INHIBIT,
    ST_PWR_WAIT,
    ST_PALL,
    ST_GAP_RP,
    ST_AREF,
    ST_GAP_RFC,
    ST_LOAD_MAIN,
    ST_GAP_MAIN,
    ST_LOAD_EXT,
    ST_GAP_EXT,
    ST_READY
  } init_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [2:0]        burst_len,
  input  logic              burst_type,
  input  logic [2:0]        cas_lat,
  input  logic              write_burst,
  output logic [ADDR_W-1:0] word
);

  localparam int unsigned WB_BIT = 9;

  always_comb begin
    word        = '0;
    word[2:0]   = burst_len;
    word[3]     = burst_type;
    word[6:4]   = cas_lat;
    word[8:7]   = 2'b00;
    word[WB_BIT] = write_burst;
  end

endmodule

// File: rtl/sdram_cmd_out.sv
module sdram_cmd_out
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sdram_cmd_e        cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BA_W-1:0]   ba_in,
  input  logic              done_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_INH;
      addr      <= '0;
      ba        <= '0;
      init_done <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_in;
      addr      <= addr_in;
      ba        <= ba_in;
      init_done <= done_in;
    end
  end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 125,
  parameter int unsigned WAIT_US   = 100,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RFC     = 10,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned REF_COUNT = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_stable,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_write_burst,
  input  logic [ADDR_W-1:0] cfg_ext_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done
);

  localparam int unsigned WAIT_CYC  = CLK_MHZ * WAIT_US;
  localparam int unsigned MAX_CYC   = max_of(max_of(WAIT_CYC, T_RP), max_of(T_RFC, T_MRD));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
  localparam int unsigned REF_W     = (REF_COUNT > 1) ? $clog2(REF_COUNT) : 1;
  localparam int unsigned PALL_BIT  = 10;
  localparam logic [CNT_W-1:0] LD_WAIT = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RFC  = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] LD_MRD  = CNT_W'(T_MRD - 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_COUNT - 1);
  localparam logic [BA_W-1:0]  BA_EXT   = BA_W'(2'b10);

  init_state_e       state_q, state_d;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic [ADDR_W-1:0] main_word;

  sdram_cmd_e        cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_d;

  sdram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .burst_len   (cfg_burst_len),
    .burst_type  (cfg_burst_type),
    .cas_lat     (cfg_cas_lat),
    .write_burst (cfg_write_burst),
    .word        (main_word)
  );

  // Next-state and timer-load logic
  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_INHIBIT: begin
        if (clk_stable) begin
          state_d  = ST_PWR_WAIT;
          tmr_load = 1'b1;
          tmr_val  = LD_WAIT;
        end
      end
      ST_PWR_WAIT: begin
        if (!clk_stable) begin
          state_d = ST_INHIBIT;
        end else if (tmr_expired) begin
          state_d = ST_PALL;
        end
      end
      ST_PALL: begin
        state_d  = ST_GAP_RP;
        tmr_load = 1'b1;
        tmr_val  = LD_RP;
      end
      ST_GAP_RP: begin
        if (tmr_expired) begin
          state_d = ST_AREF;
          ref_d   = '0;
        end
      end
      ST_AREF: begin
        state_d  = ST_GAP_RFC;
        tmr_load = 1'b1;
        tmr_val  = LD_RFC;
      end
      ST_GAP_RFC: begin
        if (tmr_expired) begin
          if (ref_q == REF_LAST) begin
            state_d = ST_LOAD_MAIN;
          end else begin
            state_d = ST_AREF;
            ref_d   = ref_q + 1'b1;
          end
        end
      end
      ST_LOAD_MAIN: begin
        state_d  = ST_GAP_MAIN;
        tmr_load = 1'b1;
        tmr_val  = LD_MRD;
      end
      ST_GAP_MAIN: begin
        if (tmr_expired) state_d = ST_LOAD_EXT;
      end
      ST_LOAD_EXT: begin
        state_d  = ST_GAP_EXT;
        tmr_load = 1'b1;
        tmr_val  = LD_MRD;
      end
      ST_GAP_EXT: begin
        if (tmr_expired) state_d = ST_READY;
      end
      ST_READY: state_d = ST_READY;
      default:  state_d = ST_INHIBIT;
    endcase
  end

  // Command for the state being entered; registered in the output stage
  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ba_d   = '0;
    unique case (state_d)
      ST_INHIBIT:   cmd_d = CMD_INH;
      ST_PALL: begin
        cmd_d            = CMD_PALL;
        addr_d[PALL_BIT] = 1'b1;
      end
      ST_AREF:      cmd_d = CMD_AREF;
      ST_LOAD_MAIN: begin
        cmd_d  = CMD_LOAD;
        addr_d = main_word;
      end
      ST_LOAD_EXT: begin
        cmd_d  = CMD_LOAD;
        addr_d = cfg_ext_word;
        ba_d   = BA_EXT;
      end
      default:      cmd_d = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INHIBIT;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
    end
  end

  sdram_cmd_out #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .cmd_in    (cmd_d),
    .addr_in   (addr_d),
    .ba_in     (ba_d),
    .done_in   (state_d == ST_READY),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done)
  );

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
  parameter int unsigned WAIT_CYC  = 12500,
  parameter int unsigned REF_COUNT = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              init_done
);

  logic [3:0]  cmd;
  logic        is_nop, is_pall, is_aref, is_load;
  logic [31:0] nop_run;
  logic [31:0] aref_seen;
  logic        pall_seen;

  assign cmd     = {cs_n, ras_n, cas_n, we_n};
  assign is_nop  = (cmd == 4'b0111);
  assign is_pall = (cmd == 4'b0010);
  assign is_aref = (cmd == 4'b0001);
  assign is_load = (cmd == 4'b0000);

  always_ff @(posedge clk) begin
    if (rst) begin
      nop_run   <= '0;
      aref_seen <= '0;
      pall_seen <= 1'b0;
    end else begin
      nop_run   <= is_nop ? ((nop_run == 32'hFFFF_FFFF) ? nop_run : nop_run + 1) : '0;
      if (is_aref) aref_seen <= aref_seen + 1;
      if (is_pall) pall_seen <= 1'b1;
    end
  end

  // R2: the precharge is preceded by the full NOP run
  a_r2_pall_after_wait: assert property (@(posedge clk) disable iff (rst)
    is_pall |-> (nop_run >= WAIT_CYC));

  // R4: the precharge addresses all banks
  a_r4_pall_all_banks: assert property (@(posedge clk) disable iff (rst)
    is_pall |-> (addr[10] && ba == '0));

  // R5: refreshes only follow the precharge
  a_r5_aref_after_pall: assert property (@(posedge clk) disable iff (rst)
    is_aref |-> pall_seen);

  // R5: the main load comes after exactly REF_COUNT refreshes
  a_r5_refs_before_load: assert property (@(posedge clk) disable iff (rst)
    (is_load && ba == '0) |-> (aref_seen == REF_COUNT));

  // R6: reserved and operating-mode bits are zero in the main load
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (is_load && ba == '0) |-> (addr[ADDR_W-1:10] == '0 && addr[8:7] == 2'b00));

  // R8: done is sticky
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R8: only NOP once done
  a_r8_nop_when_done: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_nop);

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .WAIT_CYC  (CLK_MHZ * WAIT_US),
  .REF_COUNT (REF_COUNT),
  .ADDR_W    (ADDR_W),
  .BA_W      (BA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .ba        (ba),
  .init_done (init_done)
);

// File: tb/sdram_pwrup_seq_tb_top.sv
module sdram_pwrup_seq_tb_top;

  localparam int unsigned CLK_MHZ   = 1;
  localparam int unsigned WAIT_US   = 20;
  localparam int unsigned WAIT_CYC  = CLK_MHZ * WAIT_US;
  localparam int unsigned T_RP      = 3;
  localparam int unsigned T_RFC     = 5;
  localparam int unsigned T_MRD     = 2;
  localparam int unsigned REF_COUNT = 2;

  localparam logic [3:0] C_LOAD = 4'b0000;
  localparam logic [3:0] C_AREF = 4'b0001;
  localparam logic [3:0] C_PALL = 4'b0010;
  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_INH  = 4'b1111;

  logic        clk = 1'b0;
  logic        rst;
  logic        clk_stable;
  logic [2:0]  cfg_burst_len;
  logic        cfg_burst_type;
  logic [2:0]  cfg_cas_lat;
  logic        cfg_write_burst;
  logic [11:0] cfg_ext_word;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [11:0] addr;
  logic [1:0]  ba;
  logic        init_done;

  always #5 clk = ~clk;

  sdram_pwrup_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .REF_COUNT(REF_COUNT), .ADDR_W(12), .BA_W(2)
  ) dut_i (
    .clk(clk), .rst(rst), .clk_stable(clk_stable),
    .cfg_burst_len(cfg_burst_len), .cfg_burst_type(cfg_burst_type),
    .cfg_cas_lat(cfg_cas_lat), .cfg_write_burst(cfg_write_burst),
    .cfg_ext_word(cfg_ext_word),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [11:0] addr;
    logic [1:0]  ba;
    logic        done;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;

  function automatic logic [18:0] pack_out(input logic [3:0] c, input logic [11:0] a,
                                           input logic [1:0] b, input logic d);
    return {c, a, b, d};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [11:0] a, input logic [1:0] b,
                      input logic d, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.cmd = c; e.addr = a; e.ba = b; e.done = d; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  // Expected stream from the first power-up NOP to a few cycles past done
  task automatic push_script();
    logic [11:0] mw;
    mw = {2'b00, cfg_write_burst, 2'b00, cfg_cas_lat, cfg_burst_type, cfg_burst_len};
    push(C_NOP, 12'h000, 2'b00, 1'b0, "R2", WAIT_CYC);
    push(C_PALL, 12'h400, 2'b00, 1'b0, "R4", 1);
    push(C_NOP, 12'h000, 2'b00, 1'b0, "R4", T_RP);
    for (int r = 0; r < REF_COUNT; r++) begin
      push(C_AREF, 12'h000, 2'b00, 1'b0, "R5", 1);
      push(C_NOP, 12'h000, 2'b00, 1'b0, "R5", T_RFC);
    end
    push(C_LOAD, mw, 2'b00, 1'b0, "R6", 1);
    push(C_NOP, 12'h000, 2'b00, 1'b0, "R7", T_MRD);
    push(C_LOAD, cfg_ext_word, 2'b10, 1'b0, "R7", 1);
    push(C_NOP, 12'h000, 2'b00, 1'b0, "R7", T_MRD);
    push(C_NOP, 12'h000, 2'b00, 1'b1, "R8", 4);
  endtask

  // Monitor: compare one expected item per cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, 32'(pack_out({cs_n, ras_n, cas_n, we_n}, addr, ba, init_done)),
              32'(pack_out(e.cmd, e.addr, e.ba, e.done)));
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    clk_stable = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    clk_stable = 1'b0;
    cfg_burst_len = 3'b011; cfg_burst_type = 1'b1; cfg_cas_lat = 3'b011;
    cfg_write_burst = 1'b1; cfg_ext_word = 12'h020;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: in reset
    check("R1", 32'(pack_out({cs_n, ras_n, cas_n, we_n}, addr, ba, init_done)),
          32'(pack_out(C_INH, 12'h000, 2'b00, 1'b0)));
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    // R1: first cycle after reset
    check("R1", 32'(pack_out({cs_n, ras_n, cas_n, we_n}, addr, ba, init_done)),
          32'(pack_out(C_INH, 12'h000, 2'b00, 1'b0)));

    // R2: inhibit while clock not stable
    @(posedge clk); #1;
    push(C_INH, 12'h000, 2'b00, 1'b0, "R2", 5);
    drain();

    // Scenario A: clean power-up; clk_stable toggles after the wait (R9)
    @(posedge clk); #1;
    clk_stable = 1'b1;
    push(C_INH, 12'h000, 2'b00, 1'b0, "R2", 1);
    push_script();
    repeat (WAIT_CYC + 3) @(posedge clk);
    #1 clk_stable = 1'b0;
    repeat (4) @(posedge clk);
    #1 clk_stable = 1'b1;
    drain();
    @(negedge clk);
    check("R9", 32'(pack_out({cs_n, ras_n, cas_n, we_n}, addr, ba, init_done)),
          32'(pack_out(C_NOP, 12'h000, 2'b00, 1'b1)));
    clk_stable = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", 32'(init_done), 32'd1);

    // R1: reset clears done
    do_reset();
    @(negedge clk);
    check("R1", 32'(pack_out({cs_n, ras_n, cas_n, we_n}, addr, ba, init_done)),
          32'(pack_out(C_INH, 12'h000, 2'b00, 1'b0)));

    // Scenario B: different fields, clk_stable glitch during the wait (R3)
    cfg_burst_len = 3'b000; cfg_burst_type = 1'b0; cfg_cas_lat = 3'b010;
    cfg_write_burst = 1'b0; cfg_ext_word = 12'h005;
    @(posedge clk); #1;
    clk_stable = 1'b1;
    push(C_INH, 12'h000, 2'b00, 1'b0, "R2", 1);
    push(C_NOP, 12'h000, 2'b00, 1'b0, "R3", 7);
    repeat (7) @(posedge clk);
    #1 clk_stable = 1'b0;
    push(C_INH, 12'h000, 2'b00, 1'b0, "R3", 3);
    repeat (3) @(posedge clk);
    #1 clk_stable = 1'b1;
    push_script();
    drain();

    // Scenario C: all field bits set
    do_reset();
    cfg_burst_len = 3'b111; cfg_burst_type = 1'b1; cfg_cas_lat = 3'b111;
    cfg_write_burst = 1'b1; cfg_ext_word = 12'hFFF;
    @(posedge clk); #1;
    clk_stable = 1'b1;
    push(C_INH, 12'h000, 2'b00, 1'b0, "R2", 1);
    push_script();
    drain();
    @(negedge clk);
    finish_run();
  end

endmodule